// File: doc/BRIEF.md
# Two-Bank SDRAM Controller

This block sits between a simple host request port and a single 16-bit synchronous DRAM. The memory has two internal banks of 512K words each. The host presents a 20-bit word address, a write flag, write data and two byte enables. The controller turns each request into a closed-page command sequence on the memory pins: activate the row, issue the column read or write, then precharge. Read data returns on a separate valid/data pair a fixed number of cycles later.

After reset the controller runs the power-up sequence by itself. It waits with NOP commands, precharges every bank, issues the required auto refreshes and programs the mode register. Only then does it raise its ready flag and accept host traffic. From that point a free-running timer requests one auto refresh per refresh slot. A pending refresh lets the current access finish and then wins over new host requests. All memory timings are parameters counted in clocks, and every wait is filled with NOP commands.

Top module: `sdc_ctrl`

## Requirements
- R1: While reset is asserted, chip select is high (deselected), the data bus output enable is low, and both `init_done` and `req_ready` are low.
- R2: After reset, only NOP commands appear for at least CLK_MHZ*INIT_US cycles. Then come a precharge with A10 high, at least INIT_REFS (default 2) auto refreshes, and one mode register set whose address bus is 12'h030 (A2..A0 = 000 for burst length 1, A3 = 0 for sequential wrap, A6..A4 = 011 for CAS latency 3, all other bits 0). `init_done` then rises and never falls.
- R3: Commands are encoded on {RAS#, CAS#, WE#} with chip select low: NOP 111, ACTIVE 011, READ 101, WRITE 100, PRECHARGE 010, AUTO REFRESH 001, MODE SET 000. Code 110 is never issued.
- R4: For host address `a`, ACTIVE drives A11 = a[19] and A10..A0 = a[18:8]. READ and WRITE drive A11 = a[19], A10 and A9..A8 low, and A7..A0 = a[7:0].
- R5: The output enable is high only in the cycle carrying a WRITE command. In that cycle the data output equals the host write data, and mask pin i equals the inverse of byte enable i, where pin 0 gates bits 7..0 and pin 1 gates bits 15..8. A high mask pin leaves that byte of memory unchanged, so a write with both enables low changes nothing.
- R6: The controller samples the data bus three clocks after the memory registers READ. `rd_valid` pulses exactly 4 cycles after READ appears on the pins.
- R7: Every access ends with a precharge carrying A10 high (all banks).
- R8: ACTIVE to READ/WRITE is at least T_RCD cycles. PRECHARGE to ACTIVE or AUTO REFRESH is at least T_RP. ACTIVE or AUTO REFRESH to the next ACTIVE or AUTO REFRESH is at least T_RC. WRITE to PRECHARGE is at least T_WR.
- R9: Once `init_done` is high, no more than CLK_MHZ*15.6 + 32 cycles pass without an AUTO REFRESH, and every refresh is issued with all banks precharged.
- R10: A refresh is preceded by its own all-bank precharge. From that precharge until the refresh command, `req_ready` stays low.
- R11: A read returns, per byte, the value of that byte from the last write that enabled it, for any address in either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: bank, row, column |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_ready | output | 1 | Request accepted at this edge when valid |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| init_done | output | 1 | Power-up sequence complete |
| sd_cs_n | output | 1 | Memory chip select, active low |
| sd_ras_n | output | 1 | Row strobe command pin |
| sd_cas_n | output | 1 | Column strobe command pin |
| sd_we_n | output | 1 | Write enable command pin |
| sd_addr | output | 12 | Multiplexed address, A11 = bank |
| sd_dqm | output | 2 | Byte mask pins, high = masked |
| sd_dq_in | input | 16 | Data bus from memory |
| sd_dq_out | output | 16 | Data bus to memory |
| sd_dq_oe | output | 1 | Data bus output enable |

## Verification
A wrong state in the sequencer shows on the command pins within one clock. A command comes out too early, breaks a bank-state rule, or carries the wrong address. A reference model of the memory checks every clock, so these faults are caught on the same cycle. A fault in the read capture pipeline shows as a `rd_valid` pulse off its fixed 4-cycle slot, or as data from the wrong cycle. The refresh timer is checked through the refresh deadline, which the model tracks on every cycle. A refresh that never comes is reported within one refresh slot.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   localparam int BANK_W   = 1;
   localparam int ROW_W    = 11;
   localparam int COL_W    = 8;
   localparam int DATA_W   = 16;
   localparam int BYTES    = DATA_W / 8;
   localparam int ADDR_W   = BANK_W + ROW_W + COL_W;
   localparam int PIN_A_W  = 12;
   localparam int BANK_PIN = PIN_A_W - 1;
   localparam int AP_BIT   = 10;
   localparam int CAS_LAT  = 3;

   // mode word: write burst mode, op mode, latency, wrap type, burst length
   localparam logic [PIN_A_W-1:0] MODE_WORD =
      {3'b000, 2'b00, 3'(CAS_LAT), 1'b0, 3'b000};

   typedef enum logic [2:0] {
      CMD_MRS = 3'b000,
      CMD_REF = 3'b001,
      CMD_PRE = 3'b010,
      CMD_ACT = 3'b011,
      CMD_WR  = 3'b100,
      CMD_RD  = 3'b101,
      CMD_BST = 3'b110,
      CMD_NOP = 3'b111
   } sdc_cmd_e;

   typedef enum logic [3:0] {
      ST_RESET,
      ST_PWRUP,
      ST_INIT_PRE_W,
      ST_INIT_REF_W,
      ST_INIT_MRS_W,
      ST_IDLE,
      ST_RCD_W,
      ST_RD_W,
      ST_WR_W,
      ST_PRE_W,
      ST_RFP_W
   } sdc_state_e;
endpackage

// File: rtl/sdc_wait_timer.sv
module sdc_wait_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   if (W < 1) begin : g_bad_width
      $error("sdc_wait_timer: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);

   // a new wait must never cut a running one short
   assert_load_when_done_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      load |-> done);
endmodule

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
   parameter int PERIOD = 1950
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ack,
   output logic pend
);
   localparam int CW = $clog2(PERIOD);

   if (PERIOD < 16) begin : g_bad_period
      $error("sdc_refresh_timer: PERIOD too small");
   end

   logic [CW-1:0] cnt;
   logic          tick;

   assign tick = run && (cnt == CW'(PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (!run || tick) cnt <= '0;
         else              cnt <= cnt + 1'b1;
         if (tick)         pend <= 1'b1;
         else if (ack)     pend <= 1'b0;
      end
   end

   // a slot expiring while the previous request is still unserved loses a refresh
   assert_no_missed_refresh_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (!pend || ack));
endmodule

// File: rtl/sdc_rd_capture.sv
module sdc_rd_capture #(
   parameter int LAT = 4,
   parameter int DW  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic [DW-1:0] dq_in,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);
   if (LAT < 2) begin : g_bad_lat
      $error("sdc_rd_capture: LAT must be at least 2");
   end

   logic [LAT-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr[0] <= 1'b0;
      else        sr[0] <= issue;
   end

   for (genvar i = 1; i < LAT; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr[i] <= 1'b0;
         else        sr[i] <= sr[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= sr[LAT-1];
         if (sr[LAT-1]) rd_data <= dq_in;
      end
   end

   // closed-page spacing leaves at most one read in the pipe
   assert_one_read_in_flight_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sr));
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
   import sdc_pkg::*;
#(
   parameter int CLK_MHZ   = 125,
   parameter int INIT_US   = 200,
   parameter int REF_DS    = 156,   // refresh slot in tenths of a microsecond
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RC      = 9,
   parameter int T_WR      = 2,
   parameter int T_MRD     = 2,
   parameter int INIT_REFS = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [19:0] req_addr,
   input  logic [15:0] req_wdata,
   input  logic [1:0]  req_be,
   output logic        req_ready,
   output logic        rd_valid,
   output logic [15:0] rd_data,
   output logic        init_done,
   output logic        sd_cs_n,
   output logic        sd_ras_n,
   output logic        sd_cas_n,
   output logic        sd_we_n,
   output logic [11:0] sd_addr,
   output logic [1:0]  sd_dqm,
   input  logic [15:0] sd_dq_in,
   output logic [15:0] sd_dq_out,
   output logic        sd_dq_oe
);
   localparam int INIT_CYC = CLK_MHZ * INIT_US;
   localparam int REF_CYC  = (CLK_MHZ * REF_DS) / 10;
   localparam int TW       = $clog2(INIT_CYC + 1);
   localparam int NW       = $clog2(INIT_REFS + 1);

   if (T_RCD < 1 || T_RP < 1 || T_RC < 1 || T_WR < 1 || T_MRD < 1) begin : g_bad_timing
      $error("sdc_ctrl: every timing parameter must be at least one clock");
   end
   if (INIT_REFS < 2) begin : g_bad_refs
      $error("sdc_ctrl: at least two initial refreshes are required");
   end
   if (T_RC >= INIT_CYC || T_RP >= INIT_CYC) begin : g_bad_init
      $error("sdc_ctrl: power-up wait shorter than a timing parameter");
   end
   if (ADDR_W != 20 || DATA_W != 16 || PIN_A_W != 12) begin : g_bad_geom
      $error("sdc_ctrl: port widths do not match the package geometry");
   end

   sdc_state_e          state, nxt_state;
   sdc_cmd_e            cmd_q, nxt_cmd;
   logic [PIN_A_W-1:0]  addr_q, nxt_addr;
   logic [BYTES-1:0]    dqm_q, nxt_dqm;
   logic                oe_q, nxt_oe, cs_n_q, init_q;
   logic [NW-1:0]       irefs;
   logic                t_load, t_done, rc_load, rc_done;
   logic [TW-1:0]       t_val;
   logic                ref_pend, ref_ack, rd_issue, accept, init_set, iref_inc;

   logic                hold_bank, hold_wr;
   logic [COL_W-1:0]    hold_col;
   logic [DATA_W-1:0]   hold_wdata;
   logic [BYTES-1:0]    hold_be;

   sdc_wait_timer #(.W(TW)) i_step_timer (
      .clk, .rst_n, .load(t_load), .load_val(t_val), .done(t_done));

   sdc_wait_timer #(.W(TW)) i_rc_timer (
      .clk, .rst_n, .load(rc_load), .load_val(TW'(T_RC - 1)), .done(rc_done));

   sdc_refresh_timer #(.PERIOD(REF_CYC)) i_ref_timer (
      .clk, .rst_n, .run(init_q), .ack(ref_ack), .pend(ref_pend));

   sdc_rd_capture #(.LAT(CAS_LAT + 1), .DW(DATA_W)) i_rd_capture (
      .clk, .rst_n, .issue(rd_issue), .dq_in(sd_dq_in),
      .rd_valid, .rd_data);

   assign req_ready = (state == ST_IDLE) && !ref_pend && rc_done;

   always_comb begin
      nxt_state = state;
      nxt_cmd   = CMD_NOP;
      nxt_addr  = '0;
      nxt_dqm   = '0;
      nxt_oe    = 1'b0;
      t_load    = 1'b0;
      t_val     = '0;
      rc_load   = 1'b0;
      ref_ack   = 1'b0;
      rd_issue  = 1'b0;
      accept    = 1'b0;
      init_set  = 1'b0;
      iref_inc  = 1'b0;
      unique case (state)
         ST_RESET: begin
            t_load    = 1'b1;
            t_val     = TW'(INIT_CYC - 1);
            nxt_state = ST_PWRUP;
         end
         ST_PWRUP: if (t_done) begin
            nxt_cmd          = CMD_PRE;
            nxt_addr[AP_BIT] = 1'b1;
            t_load           = 1'b1;
            t_val            = TW'(T_RP - 1);
            nxt_state        = ST_INIT_PRE_W;
         end
         ST_INIT_PRE_W: if (t_done && rc_done) begin
            nxt_cmd   = CMD_REF;
            rc_load   = 1'b1;
            iref_inc  = 1'b1;
            nxt_state = ST_INIT_REF_W;
         end
         ST_INIT_REF_W: if (rc_done) begin
            if (irefs < NW'(INIT_REFS)) begin
               nxt_cmd  = CMD_REF;
               rc_load  = 1'b1;
               iref_inc = 1'b1;
            end else begin
               nxt_cmd   = CMD_MRS;
               nxt_addr  = MODE_WORD;
               t_load    = 1'b1;
               t_val     = TW'(T_MRD - 1);
               nxt_state = ST_INIT_MRS_W;
            end
         end
         ST_INIT_MRS_W: if (t_done) begin
            init_set  = 1'b1;
            nxt_state = ST_IDLE;
         end
         ST_IDLE: if (rc_done) begin
            if (ref_pend) begin
               nxt_cmd          = CMD_PRE;
               nxt_addr[AP_BIT] = 1'b1;
               t_load           = 1'b1;
               t_val            = TW'(T_RP - 1);
               nxt_state        = ST_RFP_W;
            end else if (req_valid) begin
               accept                   = 1'b1;
               nxt_cmd                  = CMD_ACT;
               nxt_addr[ROW_W-1:0]      = req_addr[COL_W +: ROW_W];
               nxt_addr[BANK_PIN]       = req_addr[ADDR_W-1];
               rc_load                  = 1'b1;
               t_load                   = 1'b1;
               t_val                    = TW'(T_RCD - 1);
               nxt_state                = ST_RCD_W;
            end
         end
         ST_RCD_W: if (t_done) begin
            nxt_addr[COL_W-1:0] = hold_col;
            nxt_addr[BANK_PIN]  = hold_bank;
            t_load              = 1'b1;
            if (hold_wr) begin
               nxt_cmd   = CMD_WR;
               nxt_dqm   = ~hold_be;
               nxt_oe    = 1'b1;
               t_val     = TW'(T_WR - 1);
               nxt_state = ST_WR_W;
            end else begin
               nxt_cmd   = CMD_RD;
               rd_issue  = 1'b1;
               t_val     = TW'(CAS_LAT - 1);
               nxt_state = ST_RD_W;
            end
         end
         ST_RD_W, ST_WR_W: if (t_done) begin
            nxt_cmd          = CMD_PRE;
            nxt_addr[AP_BIT] = 1'b1;
            t_load           = 1'b1;
            t_val            = TW'(T_RP - 1);
            nxt_state        = ST_PRE_W;
         end
         ST_PRE_W: if (t_done) begin
            nxt_state = ST_IDLE;
         end
         ST_RFP_W: if (t_done && rc_done) begin
            nxt_cmd   = CMD_REF;
            rc_load   = 1'b1;
            ref_ack   = 1'b1;
            nxt_state = ST_IDLE;
         end
         default: nxt_state = ST_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_RESET;
         cmd_q      <= CMD_NOP;
         addr_q     <= '0;
         dqm_q      <= '0;
         oe_q       <= 1'b0;
         cs_n_q     <= 1'b1;
         init_q     <= 1'b0;
         irefs      <= '0;
         hold_bank  <= 1'b0;
         hold_wr    <= 1'b0;
         hold_col   <= '0;
         hold_wdata <= '0;
         hold_be    <= '0;
      end else begin
         state  <= nxt_state;
         cmd_q  <= nxt_cmd;
         addr_q <= nxt_addr;
         dqm_q  <= nxt_dqm;
         oe_q   <= nxt_oe;
         cs_n_q <= 1'b0;
         if (init_set) init_q <= 1'b1;
         if (iref_inc) irefs  <= irefs + 1'b1;
         if (accept) begin
            hold_bank  <= req_addr[ADDR_W-1];
            hold_wr    <= req_write;
            hold_col   <= req_addr[COL_W-1:0];
            hold_wdata <= req_wdata;
            hold_be    <= req_be;
         end
      end
   end

   assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_cs_n   = cs_n_q;
   assign sd_addr   = addr_q;
   assign sd_dq_out = hold_wdata;
   assign sd_dq_oe  = oe_q;
   assign init_done = init_q;

   for (genvar b = 0; b < BYTES; b++) begin : g_mask
      assign sd_dqm[b] = dqm_q[b];
   end

   assert_ready_after_init_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> init_done);

   assert_init_sticky_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   assert_oe_only_on_write_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      sd_dq_oe |-> (cmd_q == CMD_WR));

   assert_read_latency_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_q == CMD_RD && !sd_cs_n, CAS_LAT + 1) |-> rd_valid);

   assert_no_burst_stop_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !sd_cs_n |-> (cmd_q != CMD_BST));
endmodule

// File: tb/test_sdc_ctrl.sv
`timescale 1ns/1ps
module test_sdc_ctrl;
   localparam int CLK_MHZ  = 125;
   localparam int INIT_CYC = CLK_MHZ * 200;
   localparam int REF_CYC  = (CLK_MHZ * 156) / 10;
   localparam int T_RCD = 3, T_RP = 3, T_RC = 9, T_WR = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [19:0] req_addr;
   logic [15:0] req_wdata;
   logic [1:0]  req_be;
   logic        req_ready, rd_valid, init_done;
   logic [15:0] rd_data;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
   logic [11:0] sd_addr;
   logic [1:0]  sd_dqm;
   logic [15:0] sd_dq_in, sd_dq_out;

   always #4 clk = ~clk;

   sdc_ctrl i_sdc_ctrl (
      .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .req_be,
      .req_ready, .rd_valid, .rd_data, .init_done,
      .sd_cs_n, .sd_ras_n, .sd_cas_n, .sd_we_n, .sd_addr, .sd_dqm,
      .sd_dq_in, .sd_dq_out, .sd_dq_oe);

   int vectors = 0, errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // host-side expectations
   logic [15:0] hmem [int];
   logic [19:0] q_addr[$];
   bit          q_wr[$];
   logic [15:0] q_data[$];
   logic [1:0]  q_be[$];
   logic [15:0] q_exp[$];

   // memory reference model state
   logic [15:0] dmem [int];
   int          due_q[$];
   logic [15:0] dat_q[$];
   int          rdc_q[$];
   int  cyc = 0, last_pre = -1000, last_actref = -1000, last_wr = -1000;
   int  last_act[2] = '{-1000, -1000};
   bit  open_b[2]   = '{1'b0, 1'b0};
   int  open_row[2] = '{0, 0};
   int  nop_pre = 0, init_refs = 0, last_ref = -1, ref_count = 0;
   bit  pre_seen = 1'b0, mrs_seen = 1'b0, ref_seq = 1'b0, was_init = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [2:0] cmd;
         int b;
         cyc++;
         cmd = {sd_ras_n, sd_cas_n, sd_we_n};
         b   = int'(sd_addr[11]);
         if (due_q.size() > 0 && due_q[0] == cyc) begin
            sd_dq_in = dat_q[0];
            void'(due_q.pop_front());
            void'(dat_q.pop_front());
         end else begin
            sd_dq_in = 16'h0;
         end
         chk(!sd_dq_oe || cmd == 3'b100, "R5", "oe outside write", cmd, 3'b100);
         if (!pre_seen && cmd == 3'b111) nop_pre++;
         if (!sd_cs_n) begin
            chk(cmd != 3'b110, "R3", "illegal code", cmd, 3'b111);
            case (cmd)
               3'b011: begin
                  chk(init_done, "R2", "activate before init", 0, 1);
                  chk(cyc - last_pre >= T_RP, "R8", "tRP before ACT", cyc - last_pre, T_RP);
                  chk(cyc - last_actref >= T_RC, "R8", "tRC before ACT", cyc - last_actref, T_RC);
                  chk(!open_b[b], "R7", "bank already open", 1, 0);
                  if (q_addr.size() > 0)
                     chk(sd_addr == {q_addr[0][19], q_addr[0][18:8]}, "R4", "ACT address",
                         sd_addr, {q_addr[0][19], q_addr[0][18:8]});
                  open_b[b] = 1'b1; open_row[b] = int'(sd_addr[10:0]);
                  last_act[b] = cyc; last_actref = cyc;
               end
               3'b101, 3'b100: begin
                  int key;
                  chk(open_b[b], "R8", "column access to closed bank", 0, 1);
                  chk(cyc - last_act[b] >= T_RCD, "R8", "tRCD", cyc - last_act[b], T_RCD);
                  key = (b << 19) | (open_row[b] << 8) | int'(sd_addr[7:0]);
                  if (q_addr.size() > 0) begin
                     chk(sd_addr == {q_addr[0][19], 3'b000, q_addr[0][7:0]}, "R4", "column address",
                         sd_addr, {q_addr[0][19], 3'b000, q_addr[0][7:0]});
                     chk(q_wr[0] == (cmd == 3'b100), "R3", "access kind", cmd, q_wr[0]);
                     if (cmd == 3'b100) begin
                        chk(sd_dq_oe, "R5", "oe on write", sd_dq_oe, 1);
                        chk(sd_dqm == ~q_be[0], "R5", "mask pins", sd_dqm, ~q_be[0]);
                        chk(sd_dq_out == q_data[0], "R5", "write data", sd_dq_out, q_data[0]);
                     end
                     void'(q_addr.pop_front()); void'(q_wr.pop_front());
                     void'(q_data.pop_front()); void'(q_be.pop_front());
                  end
                  if (cmd == 3'b100) begin
                     logic [15:0] w;
                     w = dmem.exists(key) ? dmem[key] : 16'h0;
                     if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
                     if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
                     dmem[key] = w;
                     last_wr = cyc;
                  end else begin
                     due_q.push_back(cyc + 3);
                     dat_q.push_back(dmem.exists(key) ? dmem[key] : 16'h0);
                     rdc_q.push_back(cyc);
                  end
               end
               3'b010: begin
                  chk(cyc - last_wr >= T_WR, "R8", "tWR", cyc - last_wr, T_WR);
                  chk(sd_addr[10], "R7", "precharge not all-bank", sd_addr[10], 1);
                  if (!pre_seen) begin
                     chk(nop_pre >= INIT_CYC, "R2", "power-up NOP count", nop_pre, INIT_CYC);
                     pre_seen = 1'b1;
                  end
                  if (init_done && !open_b[0] && !open_b[1]) ref_seq = 1'b1;
                  open_b[0] = 1'b0; open_b[1] = 1'b0;
                  last_pre = cyc;
               end
               3'b001: begin
                  chk(!open_b[0] && !open_b[1], "R9", "refresh with open bank", 1, 0);
                  chk(cyc - last_pre >= T_RP, "R8", "tRP before REF", cyc - last_pre, T_RP);
                  chk(cyc - last_actref >= T_RC, "R8", "tRC before REF", cyc - last_actref, T_RC);
                  chk(pre_seen, "R2", "refresh before precharge", 0, 1);
                  last_actref = cyc;
                  if (init_done) begin
                     chk(ref_seq, "R10", "refresh without own precharge", 0, 1);
                     ref_seq = 1'b0;
                     last_ref = cyc;
                     ref_count++;
                  end else begin
                     init_refs++;
                  end
               end
               3'b000: begin
                  chk(sd_addr == 12'h030, "R2", "mode word", sd_addr, 12'h030);
                  chk(init_refs >= 2, "R2", "refreshes before mode set", init_refs, 2);
                  chk(!open_b[0] && !open_b[1], "R2", "mode set with open bank", 1, 0);
                  mrs_seen = 1'b1;
               end
               default: ;
            endcase
         end
         if (ref_seq) chk(!req_ready, "R10", "ready during refresh", req_ready, 0);
         if (init_done && !was_init) begin
            chk(mrs_seen, "R2", "ready before mode set", 0, 1);
            last_ref = cyc;
         end
         if (was_init) chk(init_done, "R2", "init_done fell", init_done, 1);
         was_init = init_done;
         if (init_done)
            chk(cyc - last_ref <= REF_CYC + 32, "R9", "refresh overdue", cyc - last_ref, REF_CYC + 32);
         if (rd_valid) begin
            if (rdc_q.size() > 0) begin
               chk(cyc - rdc_q[0] == 4, "R6", "read latency", cyc - rdc_q[0], 4);
               void'(rdc_q.pop_front());
            end else chk(0, "R6", "spurious rd_valid", 1, 0);
            if (q_exp.size() > 0) begin
               chk(rd_data == q_exp[0], "R11", "read data", rd_data, q_exp[0]);
               void'(q_exp.pop_front());
            end else chk(0, "R11", "unexpected read data", rd_data, 0);
         end
      end
   end

   task automatic host(input bit wr, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] be);
      logic [15:0] cur;
      cur = hmem.exists(int'(a)) ? hmem[int'(a)] : 16'h0;
      q_addr.push_back(a); q_wr.push_back(wr); q_data.push_back(d); q_be.push_back(be);
      if (wr) begin
         if (be[0]) cur[7:0]  = d[7:0];
         if (be[1]) cur[15:8] = d[15:8];
         hmem[int'(a)] = cur;
      end else begin
         q_exp.push_back(cur);
      end
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      int unsigned seed;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; req_be = '0; sd_dq_in = '0;
      repeat (3) @(negedge clk);
      chk(sd_cs_n, "R1", "cs_n in reset", sd_cs_n, 1);
      chk(!sd_dq_oe, "R1", "oe in reset", sd_dq_oe, 0);
      chk(!init_done, "R1", "init_done in reset", init_done, 0);
      chk(!req_ready, "R1", "ready in reset", req_ready, 0);
      rst_n = 1'b1;
      while (!init_done) @(negedge clk);
      // corner addresses in both banks
      host(1, 20'h00000, 16'h1234, 2'b11);
      host(1, 20'hFFFFF, 16'hABCD, 2'b11);
      host(1, 20'h7FFFF, 16'h5A5A, 2'b11);
      host(1, 20'h80000, 16'hC3C3, 2'b11);
      host(1, 20'h80001, 16'h0F0F, 2'b11);   // same row, next column
      host(0, 20'h00000, 0, 2'b11);
      host(0, 20'hFFFFF, 0, 2'b11);
      host(0, 20'h7FFFF, 0, 2'b11);
      host(0, 20'h80000, 0, 2'b11);
      host(0, 20'h80001, 0, 2'b11);
      // byte masks: low only, high only, none (R5)
      host(1, 20'h00000, 16'hEE77, 2'b01);
      host(0, 20'h00000, 0, 2'b11);
      host(1, 20'hFFFFF, 16'h99EE, 2'b10);
      host(0, 20'hFFFFF, 0, 2'b11);
      host(1, 20'h80000, 16'hFFFF, 2'b00);
      host(0, 20'h80000, 0, 2'b11);
      // idle stretch spanning refresh slots
      repeat (3 * REF_CYC) @(negedge clk);
      seed = 32'h1357_9BDF;
      for (int i = 0; i < 350; i++) begin
         logic [19:0] a;
         seed = seed * 32'd1103515245 + 32'd12345;
         a = seed[27:8];
         host(1, a, seed[15:0] ^ 16'h3C5A, 2'(i % 3 + 1));
         host(0, a, 0, 2'b11);
         if (i % 50 == 0) host(0, 20'h00000, 0, 2'b11);
      end
      repeat (30) @(negedge clk);
      chk(q_exp.size() == 0, "R11", "reads outstanding", q_exp.size(), 0);
      chk(ref_count >= 4, "R9", "refreshes seen", ref_count, 4);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         vectors++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule